// File: doc/BRIEF.md
# DRAM Column-Strobe Pattern Sequencer

This block drives the two strobes of a burst access to asynchronous DRAM. The column strobe follows a bit pattern that software writes, and the row strobe frames the whole burst. Three 32-bit pattern words are joined into one 96-bit circular pattern. When a burst is requested, the block loads a working copy of that pattern and plays it out one bit per timing tick. A 1 bit holds the active-low column strobe high for that tick, and a 0 bit pulls it low. When the last bit has played, the pattern wraps and starts again, so a burst may run longer than 96 ticks.

The row strobe goes low when the burst starts. The block counts column-strobe pulses, where one pulse is a low-to-high return of the strobe. When the count reaches the burst length that was latched at start, the row strobe is released one tick later. A tick is one clock at full rate, or two clocks when either the clock-divide select or the half-width-bus select is set. Software writes and reads the pattern words through a small address/data port. In full-rate mode, a write that leaves an illegal pattern raises a one-cycle error flag.

Top module: `cas_wave_seq`

## Requirements
- R1: After reset, busy is 0, row_strobe_n is 1, col_strobe_n is 1 and cfg_err is 0. Pattern word 0 reads back with bits 11:0 equal to 0x57F. Both strobes stay at 1 whenever busy is 0.
- R2: A write with cfg_wr_en=1 stores cfg_wdata into pattern word cfg_addr (0, 1 or 2). cfg_rdata shows the addressed word combinationally.
- R3: When burst_start=1 is sampled while idle and burst_len is not 0, then in the next cycle busy=1, row_strobe_n=0 and col_strobe_n equals bit 0 of word 0.
- R4: The pattern is P = {word2, word1, word0}, with bit 0 of word 0 as bit 0 of P. During tick k of a burst, col_strobe_n equals P[k mod 96].
- R5: After bit 95 has played, bit 0 of P follows again. The pattern keeps rotating until the burst ends.
- R6: A tick lasts 1 clock when div2_sel=0 and half_bus_sel=0. It lasts 2 clocks when either select is 1. Both selects are sampled at burst start.
- R7: A pulse is counted at each tick k where P[k-1]=0 and P[k]=1. When the count reaches the burst_len value latched at start, at the tick after that pulse's tick the block sets row_strobe_n=1 and busy=0.
- R8: burst_start has no effect while busy=1, and it has no effect when burst_len=0.
- R9: A pattern write during a burst does not change that burst's waveform or length, but the new value is still stored.
- R10: cfg_err is high for one cycle, one cycle after an accepted write, when three conditions hold. Both selects are 0 at the write. The resulting 96-bit pattern has bits 3:0 of word 0 not all 1, or it has a level run one bit long somewhere in the circular pattern. When either select is 1, no such write raises cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Pattern word write strobe |
| cfg_addr | input | 2 | Pattern word select (0..2) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |
| div2_sel | input | 1 | Clock-divide select: 1 gives two-clock ticks |
| half_bus_sel | input | 1 | Half-width bus select: forces two-clock ticks |
| burst_start | input | 1 | Burst request |
| burst_len | input | 8 | Column-strobe pulses in the burst |
| row_strobe_n | output | 1 | Row strobe, active low |
| col_strobe_n | output | 1 | Column strobe, active low |
| busy | output | 1 | High from burst start until row strobe release |
| cfg_err | output | 1 | One-cycle flag for an illegal full-rate write |

## Verification
The hardest state to reach is a burst whose final pulse arrives only after the pattern has wrapped past bit 95. To get there, the bench programs words 1 and 2 as all ones and asks for one more pulse than word 0 holds, in two-clock tick mode. It then checks every clock of the more than 200-cycle burst against its own walk of the pattern. The ignored-input cases are hard to separate from normal behaviour, so they are made visible at the ports. A second start request with a shorter length, or a pattern rewrite, is placed inside a running burst, and the strobe waveform and the release clock must stay exactly as they would be without it.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    CWS_IDLE = 2'd0,
    CWS_RUN  = 2'd1,
    CWS_TAIL = 2'd2
  } cws_state_e;

  // a tick spans two core clocks when either select asks for it
  function automatic logic cws_slow_tick(input logic div2, input logic half);
    return div2 | half;
  endfunction

  // completed column pulse: strobe returns from low to high
  function automatic logic cws_pulse_edge(input logic cur_bit, input logic next_bit);
    return !cur_bit && next_bit;
  endfunction
endpackage

// File: rtl/cws_pattern_regs.sv
module cws_pattern_regs #(
  parameter int          PAT_W    = 32,
  parameter int          NUM_REGS = 3,
  parameter int          ADDR_W   = 2,
  parameter logic [31:0] RESET0   = 32'h0000_057F,
  localparam int         SEQ_W    = PAT_W * NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAT_W-1:0]  wdata,
  input  logic              full_rate,
  output logic [PAT_W-1:0]  rdata,
  output logic [SEQ_W-1:0]  pattern,
  output logic              cfg_err
);
  logic [SEQ_W-1:0] pat_q;
  logic [SEQ_W-1:0] cand;
  logic             addr_ok;
  logic             err_d;

  // true when some level in the circular pattern lasts a single bit
  function automatic logic has_short_run(input logic [SEQ_W-1:0] p);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < SEQ_W; i++) begin
      if ((p[i] != p[(i + SEQ_W - 1) % SEQ_W]) && (p[i] != p[(i + 1) % SEQ_W]))
        bad = 1'b1;
    end
    return bad;
  endfunction

  assign addr_ok = (int'(addr) < NUM_REGS);

  always_comb begin
    cand  = pat_q;
    rdata = '0;
    for (int g = 0; g < NUM_REGS; g++) begin
      if (addr == ADDR_W'(g)) begin
        cand[g*PAT_W +: PAT_W] = wdata;
        rdata                  = pat_q[g*PAT_W +: PAT_W];
      end
    end
  end

  assign err_d = wr_en && addr_ok && full_rate &&
                 ((cand[3:0] != 4'hF) || has_short_run(cand));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= '1;
      pat_q[PAT_W-1:0] <= RESET0[PAT_W-1:0];
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= err_d;
      if (wr_en && addr_ok) pat_q <= cand;
    end
  end

  assign pattern = pat_q;
endmodule

// File: rtl/cws_tick_gen.sv
module cws_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic slow_sel,
  output logic tick
);
  logic slow_q;
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (start) begin
      slow_q  <= slow_sel;
      phase_q <= 1'b0;
    end else if (active) begin
      phase_q <= slow_q ? ~phase_q : 1'b0;
    end
  end

  assign tick = active && (!slow_q || phase_q);
endmodule

// File: rtl/cws_shift_core.sv
module cws_shift_core
  import cws_pkg::*;
#(
  parameter int SEQ_W = 96,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEQ_W-1:0] pattern,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             tick,
  output logic             col_n,
  output logic             row_n,
  output logic             busy,
  output logic             pulse_ev
);
  cws_state_e       st_q;
  logic [SEQ_W-1:0] work_q;
  logic [LEN_W-1:0] remain_q;

  assign pulse_ev = (st_q == CWS_RUN) && tick && cws_pulse_edge(work_q[0], work_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CWS_IDLE;
      work_q   <= '1;
      remain_q <= '0;
    end else begin
      unique case (st_q)
        CWS_IDLE: if (start) begin
          work_q   <= pattern;
          remain_q <= burst_len;
          st_q     <= CWS_RUN;
        end
        CWS_RUN: if (tick) begin
          work_q <= {work_q[0], work_q[SEQ_W-1:1]};
          if (pulse_ev) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) st_q <= CWS_TAIL;
          end
        end
        CWS_TAIL: if (tick) st_q <= CWS_IDLE;
        default: st_q <= CWS_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != CWS_IDLE);
  assign row_n = !busy;
  assign col_n = busy ? work_q[0] : 1'b1;
endmodule

// File: rtl/cas_wave_seq.sv
module cas_wave_seq
  import cws_pkg::*;
#(
  parameter int  PAT_W    = 32,
  parameter int  NUM_REGS = 3,
  parameter int  LEN_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int SEQ_W    = PAT_W * NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [PAT_W-1:0]  cfg_wdata,
  output logic [PAT_W-1:0]  cfg_rdata,
  input  logic              div2_sel,
  input  logic              half_bus_sel,
  input  logic              burst_start,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              row_strobe_n,
  output logic              col_strobe_n,
  output logic              busy,
  output logic              cfg_err
);
  logic [SEQ_W-1:0] pattern_w;
  logic             start_w;
  logic             tick_w;
  logic             pulse_w;
  logic             slow_w;

  assign slow_w  = cws_slow_tick(div2_sel, half_bus_sel);
  assign start_w = burst_start && !busy && (burst_len != '0);

  cws_pattern_regs #(
    .PAT_W(PAT_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .full_rate(!slow_w), .rdata(cfg_rdata),
    .pattern(pattern_w), .cfg_err(cfg_err)
  );

  cws_tick_gen tick_i (
    .clk(clk), .rst_n(rst_n), .start(start_w), .active(busy),
    .slow_sel(slow_w), .tick(tick_w)
  );

  cws_shift_core #(.SEQ_W(SEQ_W), .LEN_W(LEN_W)) core_i (
    .clk(clk), .rst_n(rst_n), .start(start_w), .pattern(pattern_w),
    .burst_len(burst_len), .tick(tick_w), .col_n(col_strobe_n),
    .row_n(row_strobe_n), .busy(busy), .pulse_ev(pulse_w)
  );
endmodule

// File: rtl/cas_wave_seq_chk.sv
module cas_wave_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             row_strobe_n,
  input logic             col_strobe_n,
  input logic             burst_start,
  input logic [LEN_W-1:0] burst_len,
  input logic             cfg_wr_en,
  input logic             cfg_err,
  input logic             start_w,
  input logic             tick_w,
  input logic             pulse_w
);
  a_r1_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (row_strobe_n && col_strobe_n));

  a_r3_row_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !row_strobe_n);

  a_r3_start_enters_burst: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (busy && !row_strobe_n));

  a_r6_col_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_w) |=> (!busy || $stable(col_strobe_n)));

  a_r7_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(col_strobe_n));

  a_r7_pulse_inside_burst: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_w |-> busy);

  a_r8_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && burst_start && (burst_len == '0)) |=> !busy);

  a_r10_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_wr_en));
endmodule

bind cas_wave_seq cas_wave_seq_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .row_strobe_n(row_strobe_n),
  .col_strobe_n(col_strobe_n), .burst_start(burst_start), .burst_len(burst_len),
  .cfg_wr_en(cfg_wr_en), .cfg_err(cfg_err), .start_w(start_w),
  .tick_w(tick_w), .pulse_w(pulse_w)
);

// File: tb/cas_wave_seq_tb_top.sv
`timescale 1ns/1ps
module cas_wave_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        div2_sel = 1'b0;
  logic        half_bus_sel = 1'b0;
  logic        burst_start = 1'b0;
  logic [7:0]  burst_len = '0;
  logic        row_strobe_n, col_strobe_n, busy, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] shadow [3];

  always #10 clk = ~clk;

  cas_wave_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .div2_sel(div2_sel),
    .half_bus_sel(half_bus_sel), .burst_start(burst_start), .burst_len(burst_len),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .busy(busy),
    .cfg_err(cfg_err)
  );

  // vector: {word0, word1, word2, len, div2, half}
  localparam logic [105:0] VECS [4] = '{
    {32'h0000_3C3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd2, 1'b0, 1'b0},
    {32'h0000_3C3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd3, 1'b1, 1'b0},
    {32'hFFFF_00FF, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 8'd4, 1'b0, 1'b1},
    {32'hAAAA_AAAB, 32'h0000_FFFF, 32'hFFFF_FFFF, 8'd6, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // release tick index: one tick after the len-th low-to-high step
  function automatic int release_tick(input logic [95:0] p, input int len);
    int cnt = 0;
    for (int k = 1; k < 4000; k++) begin
      if (p[(k - 1) % 96] == 1'b0 && p[k % 96] == 1'b1) begin
        cnt++;
        if (cnt == len) return k + 1;
      end
    end
    return -1;
  endfunction

  // walk the runs of the circular pattern; any run of length one is illegal
  function automatic bit bench_bad(input logic [95:0] p);
    int s = -1;
    int run;
    for (int i = 0; i < 96; i++) if (p[i] != p[(i + 95) % 96]) s = i;
    if (s < 0) return (p[3:0] != 4'hF);
    run = 0;
    for (int j = 0; j < 96; j++) begin
      int idx = (s + j) % 96;
      if (j > 0 && p[idx] != p[(idx + 95) % 96]) begin
        if (run == 1) return 1'b1;
        run = 0;
      end
      run++;
    end
    if (run == 1) return 1'b1;
    return (p[3:0] != 4'hF);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    logic [95:0] cand;
    bit exp_err;
    cand = {shadow[2], shadow[1], shadow[0]};
    cand[a*32 +: 32] = d;
    exp_err = !div2_sel && !half_bus_sel && bench_bad(cand);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    shadow[a] = d;
    chk(cfg_err == exp_err, "R10 write err flag", 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic readback();
    for (int a = 0; a < 3; a++) begin
      cfg_addr = 2'(a);
      #1;
      chk(cfg_rdata == shadow[a], "R2 readback", cfg_rdata, shadow[a]);
    end
  endtask

  // inj: 0 none, 1 second start while busy (R8), 2 rewrite word0 mid-burst (R9)
  task automatic run_burst(input logic [31:0] w0, w1, w2, input int len,
                           input bit d, input bit h, input int inj);
    logic [95:0] p;
    int per, rel, total, bit_i;
    string tag;
    @(negedge clk);
    div2_sel = d; half_bus_sel = h;
    wr(0, w0); wr(1, w1); wr(2, w2);
    readback();
    p = {w2, w1, w0};
    per = (d || h) ? 2 : 1;
    rel = release_tick(p, len);
    total = per * rel;
    @(negedge clk);
    burst_start = 1'b1; burst_len = 8'(len);
    @(negedge clk);
    burst_start = 1'b0;
    for (int t = 0; t <= total; t++) begin
      if (t > 0) @(negedge clk);
      if (t < total) begin
        bit_i = t / per;
        if (t == 0) tag = "R3 first bit";
        else if (inj == 2 && t > 2) tag = "R9 waveform kept";
        else if (bit_i >= 96) tag = "R5 wrapped bit";
        else if (per == 2) tag = "R6 slow tick bit";
        else tag = "R4 pattern bit";
        chk(busy && !row_strobe_n && (col_strobe_n == p[bit_i % 96]), tag,
            {29'd0, busy, row_strobe_n, col_strobe_n}, {29'd0, 1'b1, 1'b0, p[bit_i % 96]});
      end else begin
        tag = (inj == 1) ? "R8 release unchanged" : (inj == 2) ? "R9 release unchanged" : "R7 release";
        chk(!busy && row_strobe_n && col_strobe_n, tag,
            {29'd0, busy, row_strobe_n, col_strobe_n}, 32'd3);
      end
      if (t == 2 && inj == 1) begin burst_start = 1'b1; burst_len = 8'd1; end
      if (t == 2 && inj == 2) begin cfg_wr_en = 1'b1; cfg_addr = 2'd0; cfg_wdata = ~w0; end
      if (t == 3) begin burst_start = 1'b0; cfg_wr_en = 1'b0; end
    end
    if (inj == 2) begin
      shadow[0] = ~w0;
      cfg_addr = 2'd0; #1;
      chk(cfg_rdata == ~w0, "R9 new value stored", cfg_rdata, ~w0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    shadow[0] = 32'hFFFF_F57F; shadow[1] = '1; shadow[2] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && row_strobe_n && col_strobe_n && !cfg_err, "R1 reset outputs",
        {28'd0, busy, row_strobe_n, col_strobe_n, cfg_err}, 32'h6);
    cfg_addr = 2'd0; #1;
    chk(cfg_rdata[11:0] == 12'h57F, "R1 reset word0", 32'(cfg_rdata[11:0]), 32'h57F);
    shadow[0] = cfg_rdata;
    cfg_addr = 2'd1; #1; shadow[1] = cfg_rdata;
    cfg_addr = 2'd2; #1; shadow[2] = cfg_rdata;

    for (int v = 0; v < 4; v++)
      run_burst(VECS[v][105:74], VECS[v][73:42], VECS[v][41:10],
                int'(VECS[v][9:2]), VECS[v][1], VECS[v][0], 0);

    // R8 zero length ignored
    @(negedge clk);
    burst_start = 1'b1; burst_len = 8'd0;
    @(negedge clk);
    burst_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && row_strobe_n && col_strobe_n, "R8 zero length",
          {29'd0, busy, row_strobe_n, col_strobe_n}, 32'd3);
      @(negedge clk);
    end

    run_burst(32'h0000_3C3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 1'b0, 1'b0, 1);
    run_burst(32'h0000_3C3F, 32'h0000_0003, 32'hFFFF_FFFF, 3, 1'b1, 1'b0, 2);

    // R10 configuration error cases
    @(negedge clk);
    div2_sel = 1'b1; half_bus_sel = 1'b0;
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    div2_sel = 1'b0;
    wr(0, 32'h0000_00F0);
    wr(0, 32'hFFFF_FF3F);
    wr(1, 32'h0000_0004);
    div2_sel = 1'b1;
    wr(1, 32'h0000_0010);
    div2_sel = 1'b0; half_bus_sel = 1'b1;
    wr(0, 32'h0000_0002);
    half_bus_sel = 1'b0;
    @(negedge clk);
    chk(!cfg_err, "R10 single cycle flag", 32'(cfg_err), 32'd0);
    readback();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule